// File: doc/BRIEF.md
# UART FIFO and interrupt controller

This block sits between the serial engine of a UART and the host. It holds one byte queue in each direction, 32 entries deep by default. It reports how full each queue is and raises a single interrupt line from eight latched event flags. The serial shifters and the baud generator are separate blocks. On the line side, the block accepts received bytes as single-cycle strobes. It presents the head of the transmit queue with a valid flag and removes that byte when the shifter pulses a pop. The line side also delivers parity, framing and break error pulses.

The host reaches the block through a plain register port. Writes take effect on the clock edge. Read data is combinational from the address. A read strobe on the receive data register removes one byte. Watermark events fire once when a queue crosses its programmed level. An inactivity timer covers short receive bursts that never reach the receive watermark. The timer restarts on every arriving character and flags a timeout when bytes sit in the receive queue with no new character for a programmed number of cycles.

Top module: `uart_fifo_intc`

## Requirements
- R1: Writing the FIFO control register (address 2) with bit 0 set empties the receive queue, and with bit 1 set empties the transmit queue. Both bits act once and read back as 0. A byte that arrives in the same cycle as a receive clear is lost.
- R2: Each queue delivers bytes in arrival order. A write to address 4 enqueues a transmit byte. `txByte` shows the transmit head while `txValid` is high, and a `txPop` pulse removes it. A read strobe on address 5 returns the receive head and removes it.
- R3: The FIFO status register (address 3) holds the transmit level in bits 5:0 and the receive level in bits 21:16. A level of 32 means full and 0 means empty. Reading address 5 while the receive queue is empty returns 0 and changes nothing.
- R4: FIFO control bits 4:3 select the receive watermark, with codes 0, 1, 2, 3 giving 1, 4, 8, 16 bytes. Bits 6:5 select the transmit watermark, with codes 0, 1, 2, 3 giving 2, 4, 8, 16 bytes.
- R5: Interrupt bit positions, shared by the state register (address 0) and the enable register (address 1): bit 0 transmit watermark, 1 receive watermark, 2 transmit overflow, 3 receive overflow, 4 frame error, 5 break error, 6 receive timeout, 7 parity error.
- R6: A state bit stays set until the host writes 1 to that bit at address 0. When a hardware event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: A transmit write while that queue is full is discarded and sets bit 2. A received byte arriving while that queue is full is discarded and sets bit 3. The stored contents are unchanged in both cases.
- R8: A pulse on `rxFrameErr`, `rxBreakErr` or `rxParityErr` sets bit 4, 5 or 7 respectively on the following edge.
- R9: Bit 1 is set once, in the cycle after the receive level rises from below its watermark to at or above it. It is not set again while the level stays at or above the watermark.
- R10: Bit 0 is set once, in the cycle after the transmit level falls from at or above its watermark to below it. An empty queue out of reset does not set it.
- R11: The 16-bit timeout register (address 6) holds N, and 0 turns the timer off. While the receive queue holds at least one byte but fewer than the watermark, bit 6 is set N cycles after the edge that accepted the last character. Each new character restarts the count, so characters spaced closer than N never set bit 6.
- R12: `irq` is high exactly when some bit is set in both the state and enable registers. Only bits 7:0 of the enable register are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops RX at address 5) |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the current address |
| rxByteValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| rxParityErr | input | 1 | Parity error pulse |
| rxFrameErr | input | 1 | Framing error pulse |
| rxBreakErr | input | 1 | Break condition pulse |
| txPop | input | 1 | Shifter took the transmit head |
| txByte | output | 8 | Transmit queue head |
| txValid | output | 1 | Transmit queue not empty |
| irq | output | 1 | Combined interrupt |

## Verification
The latched flags and the two queue pointers are the block's hidden state. A wrong flag appears on `irq` and in the state register on the edge after the event. A pointer or level fault appears in the status register at once and in the byte order a few reads later. Edge trackers that miss a crossing leave a watermark bit low while the level has visibly passed the threshold. A timer that is off by one cycle moves bit 6 by one cycle. For that reason the timeout is sampled in the cycle before and the cycle after its due edge.

// File: rtl/ufi_pkg.sv
package ufi_pkg;

  typedef enum logic [2:0] {
    ADDR_STATE   = 3'd0,
    ADDR_ENABLE  = 3'd1,
    ADDR_FCTRL   = 3'd2,
    ADDR_FSTAT   = 3'd3,
    ADDR_TXDATA  = 3'd4,
    ADDR_RXDATA  = 3'd5,
    ADDR_TIMEOUT = 3'd6
  } regAddrE;

  localparam int unsigned NUM_IRQ     = 8;
  localparam int unsigned IRQ_TXWM    = 0;
  localparam int unsigned IRQ_RXWM    = 1;
  localparam int unsigned IRQ_TXOVF   = 2;
  localparam int unsigned IRQ_RXOVF   = 3;
  localparam int unsigned IRQ_FRAME   = 4;
  localparam int unsigned IRQ_BREAK   = 5;
  localparam int unsigned IRQ_TIMEOUT = 6;
  localparam int unsigned IRQ_PARITY  = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic rxClr;
    logic txPush;
    logic txPop;
    logic txClr;
  } fifoStrobeT;

endpackage

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // push and pop are pre-qualified by the control (never push full, never pop empty)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= pushData;
  end

  assign head = mem[rdPtr];

endmodule

// File: rtl/ufi_datapath.sv
module ufi_datapath
  import ufi_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobeT    strb,
  input  logic [7:0]    txWdata,
  input  logic [7:0]    rxWdata,
  output logic [7:0]    txHead,
  output logic [7:0]    rxHead,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel
);

  ufi_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (strb.txClr),
    .push     (strb.txPush),
    .pushData (txWdata),
    .pop      (strb.txPop),
    .head     (txHead),
    .level    (txLevel)
  );

  ufi_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (strb.rxClr),
    .push     (strb.rxPush),
    .pushData (rxWdata),
    .pop      (strb.rxPop),
    .head     (rxHead),
    .level    (rxLevel)
  );

endmodule

// File: rtl/ufi_control.sv
module ufi_control
  import ufi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TO_W  = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               rxByteValid,
  input  logic               txPop,
  input  logic               rxParityErr,
  input  logic               rxFrameErr,
  input  logic               rxBreakErr,
  input  logic [LW-1:0]      txLevel,
  input  logic [LW-1:0]      rxLevel,
  input  logic [7:0]         rxHead,
  output fifoStrobeT         strb,
  output logic [NUM_IRQ-1:0] intrState,
  output logic [NUM_IRQ-1:0] intrEn,
  output logic               irq
);

  logic [1:0]      rxSel, txSel;
  logic [TO_W-1:0] toLimit, toCnt;
  logic [LW-1:0]   rxThr, txThr;
  logic            wrState, wrEnable, wrCtrl, wrTx, wrTimeout, rdRx;
  logic            txFull, rxFull, rxAbove, txBelow, rxAboveQ, txBelowQ;
  logic            toCond, toHit;
  logic [NUM_IRQ-1:0] setVec, clrMask;

  // register decode
  always_comb begin
    wrState   = regWe && (regAddr == ADDR_STATE);
    wrEnable  = regWe && (regAddr == ADDR_ENABLE);
    wrCtrl    = regWe && (regAddr == ADDR_FCTRL);
    wrTx      = regWe && (regAddr == ADDR_TXDATA);
    wrTimeout = regWe && (regAddr == ADDR_TIMEOUT);
    rdRx      = regRe && (regAddr == ADDR_RXDATA);
  end

  assign txFull = (txLevel == LW'(DEPTH));
  assign rxFull = (rxLevel == LW'(DEPTH));

  // strobes to the datapath; full is judged before any same-cycle pop
  always_comb begin
    strb.txPush = wrTx && !txFull;
    strb.txPop  = txPop && (txLevel != '0);
    strb.txClr  = wrCtrl && regWdata[1];
    strb.rxPush = rxByteValid && !rxFull;
    strb.rxPop  = rdRx && (rxLevel != '0);
    strb.rxClr  = wrCtrl && regWdata[0];
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSel   <= '0;
      txSel   <= '0;
      intrEn  <= '0;
      toLimit <= '0;
    end else begin
      if (wrCtrl) begin
        rxSel <= regWdata[4:3];
        txSel <= regWdata[6:5];
      end
      if (wrEnable)  intrEn  <= regWdata[NUM_IRQ-1:0];
      if (wrTimeout) toLimit <= regWdata[TO_W-1:0];
    end
  end

  // thresholds: rx 1,4,8,16 ; tx 2,4,8,16
  always_comb begin
    rxThr = (rxSel == 2'd0) ? LW'(1) : (LW'(2) << rxSel);
    txThr = LW'(2) << txSel;
  end

  assign rxAbove = (rxLevel >= rxThr);
  assign txBelow = (txLevel < txThr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAboveQ <= 1'b0;
      txBelowQ <= 1'b1;
    end else begin
      rxAboveQ <= rxAbove;
      txBelowQ <= txBelow;
    end
  end

  // inactivity timer
  assign toCond = (rxLevel != '0) && !rxAbove && (toLimit != '0);
  assign toHit  = toCond && !rxByteValid && (toCnt == toLimit - TO_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (rxByteValid || !toCond) begin
      toCnt <= '0;
    end else if (toCnt != toLimit) begin
      toCnt <= toCnt + TO_W'(1);
    end
  end

  // event collection
  always_comb begin
    setVec              = '0;
    setVec[IRQ_TXWM]    = txBelow && !txBelowQ;
    setVec[IRQ_RXWM]    = rxAbove && !rxAboveQ;
    setVec[IRQ_TXOVF]   = wrTx && txFull;
    setVec[IRQ_RXOVF]   = rxByteValid && rxFull;
    setVec[IRQ_FRAME]   = rxFrameErr;
    setVec[IRQ_BREAK]   = rxBreakErr;
    setVec[IRQ_TIMEOUT] = toHit;
    setVec[IRQ_PARITY]  = rxParityErr;
    clrMask = wrState ? regWdata[NUM_IRQ-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intrState <= '0;
    else       intrState <= (intrState & ~clrMask) | setVec;
  end

  assign irq = |(intrState & intrEn);

  // read mux
  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_STATE:   regRdata[NUM_IRQ-1:0] = intrState;
      ADDR_ENABLE:  regRdata[NUM_IRQ-1:0] = intrEn;
      ADDR_FCTRL:   regRdata[6:3] = {txSel, rxSel};
      ADDR_FSTAT: begin
        regRdata[0 +: LW]  = txLevel;
        regRdata[16 +: LW] = rxLevel;
      end
      ADDR_RXDATA:  regRdata[7:0] = (rxLevel != '0) ? rxHead : 8'h00;
      ADDR_TIMEOUT: regRdata[TO_W-1:0] = toLimit;
      default:      regRdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_fifo_intc.sv
module uart_fifo_intc
  import ufi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TO_W  = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        rxByteValid,
  input  logic [7:0]  rxByte,
  input  logic        rxParityErr,
  input  logic        rxFrameErr,
  input  logic        rxBreakErr,
  input  logic        txPop,
  output logic [7:0]  txByte,
  output logic        txValid,
  output logic        irq
);

  fifoStrobeT         strb;
  logic [LW-1:0]      txLevel, rxLevel;
  logic [7:0]         rxHead;
  logic [NUM_IRQ-1:0] intrState, intrEn;

  ufi_control #(.DEPTH(DEPTH), .TO_W(TO_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regRe       (regRe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .rxByteValid (rxByteValid),
    .txPop       (txPop),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr),
    .rxBreakErr  (rxBreakErr),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .rxHead      (rxHead),
    .strb        (strb),
    .intrState   (intrState),
    .intrEn      (intrEn),
    .irq         (irq)
  );

  ufi_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txWdata (regWdata[7:0]),
    .rxWdata (rxByte),
    .txHead  (txByte),
    .rxHead  (rxHead),
    .txLevel (txLevel),
    .rxLevel (rxLevel)
  );

  assign txValid = (txLevel != '0);

endmodule

// File: rtl/ufi_checker.sv
module ufi_checker #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWe,
  input logic [2:0]    regAddr,
  input logic [31:0]   regWdata,
  input logic          rxParityErr,
  input logic          irq,
  input logic [7:0]    intrState,
  input logic [7:0]    intrEn,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel
);

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LW'(DEPTH)) && (rxLevel <= LW'(DEPTH)));

  p_rx_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd2 && regWdata[0]) |=> (rxLevel == '0));

  p_tx_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd2 && regWdata[1]) |=> (txLevel == '0));

  // a latched bit only drops after a host write to the state register
  p_w1c_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(intrState) & ~intrState)) |-> $past(regWe && regAddr == 3'd0));

  p_tx_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd4 && txLevel == LW'(DEPTH)) |=> intrState[2]);

  p_parity_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxParityErr |=> intrState[7]);

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rstN)
    (intrEn == '0) |-> !irq);

  p_irq_needs_state_r12: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intrState != '0));

endmodule

bind uart_fifo_intc ufi_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWe       (regWe),
  .regAddr     (regAddr),
  .regWdata    (regWdata),
  .rxParityErr (rxParityErr),
  .irq         (irq),
  .intrState   (intrState),
  .intrEn      (intrEn),
  .txLevel     (txLevel),
  .rxLevel     (rxLevel)
);

// File: tb/uart_fifo_intc_bench.sv
module uart_fifo_intc_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        rxByteValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxParityErr = 1'b0, rxFrameErr = 1'b0, rxBreakErr = 1'b0;
  logic        txPop = 1'b0;
  logic [7:0]  txByte;
  logic        txValid, irq;

  int nVec = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  uart_fifo_intc u_uart_fifo_intc (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxByteValid(rxByteValid),
    .rxByte(rxByte), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rxBreakErr(rxBreakErr), .txPop(txPop), .txByte(txByte), .txValid(txValid),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] b);
    @(negedge clk);
    rxByteValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxByteValid = 1'b0;
  endtask

  task automatic txTake(output logic [7:0] b);
    @(negedge clk);
    b = txByte; txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic clearAll();
    wr(3'd2, 32'h3);
    @(negedge clk);
    wr(3'd0, 32'hFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(3'd3, d); check("R3 status after reset", d, 32'h0);
    peek(3'd0, d); check("R6 state after reset", d, 32'h0);
    check("R12 irq after reset", {31'b0, irq}, 32'h0);
    check("R2 txValid after reset", {31'b0, txValid}, 32'h0);
  endtask

  task automatic t_tx_fill();
    logic [31:0] d;
    logic [7:0] b;
    for (int i = 0; i < 33; i++) wr(3'd4, 32'(i + 8'h40));
    peek(3'd3, d); check("R3 tx full level", d, 32'd32);
    peek(3'd0, d); check("R7 tx overflow bit 2", d & 32'h4, 32'h4);
    for (int i = 0; i < 3; i++) begin
      txTake(b); check("R2 tx order", {24'b0, b}, 32'(i + 8'h40));
    end
    peek(3'd3, d); check("R7 dropped byte not stored", d, 32'd29);
    wr(3'd2, 32'h2);
    peek(3'd3, d); check("R1 tx clear", d, 32'h0);
    peek(3'd2, d); check("R1 reset bits read 0", d, 32'h0);
    clearAll();
  endtask

  task automatic t_rx();
    logic [31:0] d;
    wr(3'd2, 32'h8);  // rx watermark code 1 -> 4 bytes (R4)
    for (int i = 0; i < 3; i++) rxSend(8'hA0 + 8'(i));
    @(negedge clk);
    peek(3'd0, d); check("R9 below watermark no event", d & 32'h2, 32'h0);
    rxSend(8'hA3);
    @(negedge clk);
    peek(3'd0, d); check("R9 R4 rx watermark at 4", d & 32'h2, 32'h2);
    wr(3'd0, 32'h2);
    rxSend(8'hA4);
    @(negedge clk);
    peek(3'd0, d); check("R9 no refire above watermark", d & 32'h2, 32'h0);
    peek(3'd3, d); check("R3 rx level field", d, 32'h0005_0000);
    for (int i = 0; i < 5; i++) begin
      rd(3'd5, d); check("R2 rx order", d, 32'hA0 + 32'(i));
    end
    rd(3'd5, d); check("R3 empty read returns 0", d, 32'h0);
    peek(3'd3, d); check("R3 empty level stays 0", d, 32'h0);
    clearAll();
  endtask

  task automatic t_rx_overflow();
    logic [31:0] d;
    for (int i = 0; i < 33; i++) rxSend(8'(i));
    peek(3'd3, d); check("R7 rx full level 32", d, 32'h0020_0000);
    peek(3'd0, d); check("R7 rx overflow bit 3", d & 32'h8, 32'h8);
    rd(3'd5, d); check("R7 rx head intact", d, 32'h0);
    clearAll();
  endtask

  task automatic t_tx_wm();
    logic [31:0] d;
    logic [7:0] b;
    wr(3'd2, 32'h20);  // tx watermark code 1 -> 4 (R4)
    wr(3'd0, 32'hFF);
    for (int i = 0; i < 5; i++) wr(3'd4, 32'h10 + 32'(i));
    txTake(b);
    @(negedge clk);
    peek(3'd0, d); check("R10 level 4 not below", d & 32'h1, 32'h0);
    txTake(b);
    @(negedge clk);
    peek(3'd0, d); check("R10 tx watermark on drop to 3", d & 32'h1, 32'h1);
    clearAll();
  endtask

  task automatic t_errors();
    logic [31:0] d;
    wr(3'd1, 32'h80);
    @(negedge clk); rxFrameErr = 1'b1; @(negedge clk); rxFrameErr = 1'b0;
    peek(3'd0, d); check("R8 R5 frame bit 4", d, 32'h10);
    check("R12 masked source no irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rxParityErr = 1'b1; @(negedge clk); rxParityErr = 1'b0;
    check("R12 R5 parity bit 7 raises irq", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h80);
    check("R12 irq drops after clear", {31'b0, irq}, 32'h0);
    peek(3'd0, d); check("R6 other bit kept", d, 32'h10);
    @(negedge clk);
    rxBreakErr = 1'b1; regWe = 1'b1; regAddr = 3'd0; regWdata = 32'h20;
    @(negedge clk);
    rxBreakErr = 1'b0; regWe = 1'b0; regWdata = '0;
    peek(3'd0, d); check("R6 R8 set wins over clear", d, 32'h30);
    wr(3'd1, 32'h0);
    clearAll();
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr(3'd2, 32'h9);  // clear rx, watermark 4
    wr(3'd6, 32'd10);
    wr(3'd1, 32'h40);
    wr(3'd0, 32'hFF);
    rxSend(8'h55);
    repeat (9) @(negedge clk);
    peek(3'd0, d); check("R11 no timeout at 9 cycles", d & 32'h40, 32'h0);
    @(negedge clk);
    peek(3'd0, d); check("R11 timeout at 10 cycles", d & 32'h40, 32'h40);
    check("R11 R12 timeout irq", {31'b0, irq}, 32'h1);
    rd(3'd5, d);
    wr(3'd0, 32'hFF);
    for (int i = 0; i < 4; i++) begin
      rxSend(8'(i));
      if (i < 3) repeat (7) @(negedge clk);
    end
    @(negedge clk);
    peek(3'd0, d); check("R11 restart keeps timeout quiet, watermark reached", d & 32'h42, 32'h02);
    wr(3'd6, 32'd0);
    wr(3'd1, 32'h0);
    clearAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_fill();
    t_rx();
    t_rx_overflow();
    t_tx_wm();
    t_errors();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule